// File: doc/BRIEF.md
# Mergeable Display Plane Pixel FIFO

This block buffers pixel words between a memory fetch engine and three display planes: one graphics plane and two video planes. In the normal arrangement every plane owns a private bank of `BANK_WORDS` 64-bit words (1 kB at the default size). Each bank raises a fetch request when it runs low and keeps it raised until it is nearly full. The fetch engine answers a request with a burst of single-word writes tagged with the plane number. Each plane pulls one word per cycle through its own read strobe.

When one plane needs more headroom, the three banks can be fused into a single circular buffer of three times the size (3 kB). That buffer serves one selected plane, and the other two planes are silenced. The merged buffer is addressed as one contiguous range whose upper bits pick the bank and whose lower bits pick the word inside it. Both refill thresholds follow the capacity that is active at the time. A read from an empty buffer sets a sticky per-plane underflow flag and repeats the last good pixel.

Top module: `mergeable_plane_fifo`

## Requirements
- R1: After reset all request outputs, underflow flags and read data outputs are zero, and the block is in the unmerged mode.
- R2: In unmerged mode each plane has its own first-in first-out store of `BANK_WORDS` words. A read strobe on a non-empty store presents the oldest word on that plane's slice of `rd_data_o` (bits `p*DW` upward) from the following cycle onward.
- R3: A write to a store that is full (level equal to the active capacity) is dropped and does not disturb the stored words.
- R4: The low threshold is the active capacity minus `cfg_burst_i`, floored at zero. The request of an enabled plane is high in every cycle after its level drops to or below this threshold.
- R5: The high threshold is the active capacity minus `cfg_unit_i`. The request falls once the level reaches it. Between the two thresholds the request keeps its previous value.
- R6: A plane whose bit in `cfg_plane_en_i` is low never requests. Reads and writes aimed at it have no effect, and it raises no underflow.
- R7: A read strobe on an enabled, unsuppressed plane whose store is empty sets that plane's bit of `ufl_o`. The bit stays set until a one is written to the same bit of `ufl_clr_i`. If a set and a clear happen in the same cycle, the set wins.
- R8: On an underflowing read the plane's data output keeps the last word it delivered.
- R9: A change of `cfg_merge_i` or `cfg_sel_i` is taken only in a cycle where all of `cfg_plane_en_i` is zero. At other times the change is ignored and the stored data is kept.
- R10: Taking a mode change empties every store. Levels return to zero and all old contents are discarded.
- R11: In merged mode the selected plane (`cfg_sel_i`, 0 graphics, 1 and 2 video) owns a store of `3*BANK_WORDS` words. Its thresholds are computed from that capacity, and word order is kept across bank boundaries.
- R12: In merged mode the two planes that are not selected are suppressed. Their writes and reads have no effect, their requests stay low, and they raise no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_merge_i | input | 1 | Requested merged mode |
| cfg_sel_i | input | 2 | Plane served in merged mode |
| cfg_plane_en_i | input | 3 | Per-plane enable |
| cfg_burst_i | input | PW | Burst length in words, used for the low threshold |
| cfg_unit_i | input | PW | Buffer unit in words, used for the high threshold |
| ufl_clr_i | input | 3 | Write-one-to-clear for the underflow flags |
| wr_valid_i | input | 1 | Fetch write strobe |
| wr_plane_i | input | 2 | Plane the fetched word belongs to |
| wr_data_i | input | DW | Fetched pixel word |
| rd_en_i | input | 3 | Per-plane read strobe |
| rd_data_o | output | 3*DW | Per-plane pixel output, plane p at bits p*DW upward |
| req_o | output | 3 | Per-plane fetch request |
| ufl_o | output | 3 | Sticky per-plane underflow flags |

## Verification
The threshold assertions assume that `cfg_burst_i` and `cfg_unit_i` stay constant while a plane is active. The stimulus programs them once, before any plane is enabled, and leaves them alone afterwards. The mode-change assertion assumes that the configuration port is only handled at the block edge. The stimulus toggles the merge request both with planes enabled and with all planes disabled, so that the ignored path and the accepted path are both exercised. Write plane numbers stay within 0 to 2, which is the range the address selection is guarded for.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    localparam int NPLANE  = 3;
    localparam int PLANE_W = 2;

    // Difference clamped at zero, used for both refill thresholds.
    function automatic logic [31:0] floor_sub(input logic [31:0] a, input logic [31:0] b);
        return (a > b) ? (a - b) : 32'd0;
    endfunction
endpackage

// File: rtl/mpf_plane_ctrl.sv
module mpf_plane_ctrl #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          active_i,
    input  logic          push_i,
    input  logic          pop_req_i,
    input  logic          clr_i,
    input  logic [PW-1:0] cap_i,
    input  logic [PW-1:0] low_i,
    input  logic [PW-1:0] high_i,
    output logic [PW-1:0] wptr_o,
    output logic [PW-1:0] rptr_o,
    output logic          full_o,
    output logic          pop_o,
    output logic          req_o,
    output logic          ufl_o
);
    typedef struct packed {
        logic [PW-1:0] wptr;
        logic [PW-1:0] rptr;
        logic [PW-1:0] level;
        logic          req;
        logic          ufl;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  do_push, do_pop, empty_rd;

    always_comb begin
        s_d      = s_q;
        full_o   = (s_q.level == cap_i);
        do_push  = push_i && active_i && !full_o;
        do_pop   = pop_req_i && active_i && (s_q.level != '0);
        empty_rd = pop_req_i && active_i && (s_q.level == '0);

        if (do_push) s_d.wptr = (s_q.wptr == cap_i - PW'(1)) ? '0 : s_q.wptr + PW'(1);
        if (do_pop)  s_d.rptr = (s_q.rptr == cap_i - PW'(1)) ? '0 : s_q.rptr + PW'(1);
        if (do_push && !do_pop)      s_d.level = s_q.level + PW'(1);
        else if (!do_push && do_pop) s_d.level = s_q.level - PW'(1);

        if (clr_i)    s_d.ufl = 1'b0;
        if (empty_rd) s_d.ufl = 1'b1;

        if (!active_i)                s_d.req = 1'b0;
        else if (s_d.level <= low_i)  s_d.req = 1'b1;
        else if (s_d.level >= high_i) s_d.req = 1'b0;

        if (flush_i) begin
            s_d.wptr  = '0;
            s_d.rptr  = '0;
            s_d.level = '0;
            s_d.req   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wptr_o = s_q.wptr;
    assign rptr_o = s_q.rptr;
    assign pop_o  = do_pop;
    assign req_o  = s_q.req;
    assign ufl_o  = s_q.ufl;

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.level <= cap_i);
    assert_req_at_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i) && $stable(low_i) && s_q.level <= low_i) |-> s_q.req);
    assert_req_drop_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && $past(active_i) && $stable(low_i) && $stable(high_i)
         && s_q.level >= high_i && s_q.level > low_i) |-> !s_q.req);
    assert_idle_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !s_q.req);
    assert_ufl_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ufl && !clr_i) |=> s_q.ufl);
endmodule

// File: rtl/mpf_banks.sv
module mpf_banks #(
    parameter int DW     = 64,
    parameter int NBANK  = 3,
    parameter int OFS_W  = 7,
    parameter int BANK_W = 2,
    parameter int NPORT  = 3
) (
    input  logic                          clk,
    input  logic                          we_i,
    input  logic [BANK_W+OFS_W-1:0]       waddr_i,
    input  logic [DW-1:0]                 wdata_i,
    input  logic [NPORT-1:0][BANK_W+OFS_W-1:0] raddr_i,
    output logic [NPORT-1:0][DW-1:0]      rdata_o
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DW-1:0] mem [NBANK][DEPTH];

    logic [BANK_W-1:0] wbank;
    logic [OFS_W-1:0]  wofs;
    assign wbank = waddr_i[BANK_W+OFS_W-1:OFS_W];
    assign wofs  = waddr_i[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (we_i && (int'(wbank) < NBANK)) mem[wbank][wofs] <= wdata_i;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        logic [BANK_W-1:0] rbank;
        logic [OFS_W-1:0]  rofs;
        assign rbank = raddr_i[p][BANK_W+OFS_W-1:OFS_W];
        assign rofs  = raddr_i[p][OFS_W-1:0];
        assign rdata_o[p] = (int'(rbank) < NBANK) ? mem[rbank][rofs] : '0;
    end
endmodule

// File: rtl/mergeable_plane_fifo.sv
module mergeable_plane_fifo #(
    parameter int DW         = 64,
    parameter int BANK_WORDS = 128,
    localparam int NB        = mpf_pkg::NPLANE,
    localparam int TOTAL     = NB * BANK_WORDS,
    localparam int PW        = $clog2(TOTAL + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_merge_i,
    input  logic [mpf_pkg::PLANE_W-1:0]  cfg_sel_i,
    input  logic [NB-1:0]                cfg_plane_en_i,
    input  logic [PW-1:0]                cfg_burst_i,
    input  logic [PW-1:0]                cfg_unit_i,
    input  logic [NB-1:0]                ufl_clr_i,
    input  logic                         wr_valid_i,
    input  logic [mpf_pkg::PLANE_W-1:0]  wr_plane_i,
    input  logic [DW-1:0]                wr_data_i,
    input  logic [NB-1:0]                rd_en_i,
    output logic [NB*DW-1:0]             rd_data_o,
    output logic [NB-1:0]                req_o,
    output logic [NB-1:0]                ufl_o
);
    localparam int SW     = mpf_pkg::PLANE_W;
    localparam int OFS_W  = $clog2(BANK_WORDS);
    localparam int BANK_W = $clog2(NB);
    localparam int AW     = BANK_W + OFS_W;

    typedef struct packed {
        logic                   merge;
        logic [SW-1:0]          sel;
        logic [NB-1:0][DW-1:0]  rd;
    } top_t;

    top_t s_d, s_q;

    logic                 flush;
    logic [PW-1:0]        cap, low, high;
    logic [NB-1:0]        active, full, pop;
    logic [NB-1:0][PW-1:0] wptr, rptr;
    logic [NB-1:0][AW-1:0] raddr;
    logic [NB-1:0][DW-1:0] rdata;
    logic [AW-1:0]        waddr;
    logic                 we, wr_ok;

    always_comb begin
        s_d   = s_q;
        flush = 1'b0;
        if (cfg_plane_en_i == '0 && (cfg_merge_i != s_q.merge || cfg_sel_i != s_q.sel)) begin
            s_d.merge = cfg_merge_i;
            s_d.sel   = cfg_sel_i;
            flush     = 1'b1;
        end

        cap  = s_q.merge ? PW'(TOTAL) : PW'(BANK_WORDS);
        low  = PW'(mpf_pkg::floor_sub(32'(cap), 32'(cfg_burst_i)));
        high = PW'(mpf_pkg::floor_sub(32'(cap), 32'(cfg_unit_i)));

        for (int p = 0; p < NB; p++) begin
            active[p] = cfg_plane_en_i[p] && (!s_q.merge || s_q.sel == SW'(p));
            raddr[p]  = s_q.merge ? AW'(rptr[p]) : {BANK_W'(p), rptr[p][OFS_W-1:0]};
            if (pop[p]) s_d.rd[p] = rdata[p];
        end

        wr_ok = int'(wr_plane_i) < NB;
        we    = wr_valid_i && wr_ok && active[wr_plane_i] && !full[wr_plane_i];
        waddr = s_q.merge ? AW'(wptr[wr_plane_i])
                          : {BANK_W'(wr_plane_i), wptr[wr_plane_i][OFS_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar p = 0; p < NB; p++) begin : g_plane
        mpf_plane_ctrl #(.PW(PW)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush_i  (flush),
            .active_i (active[p]),
            .push_i   (wr_valid_i && wr_plane_i == SW'(p)),
            .pop_req_i(rd_en_i[p]),
            .clr_i    (ufl_clr_i[p]),
            .cap_i    (cap),
            .low_i    (low),
            .high_i   (high),
            .wptr_o   (wptr[p]),
            .rptr_o   (rptr[p]),
            .full_o   (full[p]),
            .pop_o    (pop[p]),
            .req_o    (req_o[p]),
            .ufl_o    (ufl_o[p])
        );
    end

    mpf_banks #(.DW(DW), .NBANK(NB), .OFS_W(OFS_W), .BANK_W(BANK_W), .NPORT(NB)) u_banks (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wr_data_i),
        .raddr_i (raddr),
        .rdata_o (rdata)
    );

    assign rd_data_o = s_q.rd;

    assert_mode_change_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.merge != $past(s_q.merge)) |-> ($past(cfg_plane_en_i) == '0));
    assert_merged_single_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.merge |-> $onehot0(req_o));
endmodule

// File: tb/sim_mergeable_plane_fifo.sv
module sim_mergeable_plane_fifo;
    localparam int DW = 64;
    localparam int BW = 128;
    localparam int PW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_merge = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [2:0]    cfg_en = 3'b000;
    logic [PW-1:0] cfg_burst = PW'(32);
    logic [PW-1:0] cfg_unit = PW'(4);
    logic [2:0]    ufl_clr = 3'b000;
    logic          wr_valid = 1'b0;
    logic [1:0]    wr_plane = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic [2:0]    rd_en = 3'b000;
    logic [3*DW-1:0] rd_data;
    logic [2:0]    req, ufl;

    mergeable_plane_fifo #(.DW(DW), .BANK_WORDS(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_merge_i(cfg_merge), .cfg_sel_i(cfg_sel),
        .cfg_plane_en_i(cfg_en), .cfg_burst_i(cfg_burst), .cfg_unit_i(cfg_unit),
        .ufl_clr_i(ufl_clr), .wr_valid_i(wr_valid), .wr_plane_i(wr_plane),
        .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .req_o(req), .ufl_o(ufl)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    int wcnt[3] = '{0, 0, 0};
    int rcnt[3] = '{0, 0, 0};
    int lvl[3]  = '{0, 0, 0};
    logic [DW-1:0] last[3] = '{64'd0, 64'd0, 64'd0};
    bit mm = 0;
    int msel = 0;

    // vector: [18] op (0 write,1 read), [17:16] plane, [15:6] count, [5:3] req, [2:0] ufl
    localparam logic [18:0] VEC [9] = '{
        {1'b0, 2'd0, 10'd100, 3'b111, 3'b000},
        {1'b0, 2'd0, 10'd24,  3'b110, 3'b000},
        {1'b1, 2'd0, 10'd27,  3'b110, 3'b000},
        {1'b1, 2'd0, 10'd1,   3'b111, 3'b000},
        {1'b0, 2'd1, 10'd124, 3'b101, 3'b000},
        {1'b1, 2'd2, 10'd1,   3'b101, 3'b100},
        {1'b0, 2'd2, 10'd130, 3'b001, 3'b100},
        {1'b1, 2'd2, 10'd128, 3'b101, 3'b100},
        {1'b1, 2'd1, 10'd28,  3'b111, 3'b100}
    };

    function automatic logic [DW-1:0] word(input int p, input int n);
        return (64'(p) << 32) | 64'(n);
    endfunction

    function automatic bit act(input int p);
        return cfg_en[p] && (!mm || msel == p);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic put(input int p, input int n);
        int capm;
        capm = mm ? 3*BW : BW;
        for (int i = 0; i < n; i++) begin
            wr_valid = 1'b1;
            wr_plane = 2'(p);
            wr_data  = word(p, wcnt[p]);
            if (act(p) && lvl[p] < capm) begin
                wcnt[p]++;
                lvl[p]++;
            end
            @(negedge clk);
        end
        wr_valid = 1'b0;
    endtask

    task automatic take(input int p, input int n, input string tag);
        logic [DW-1:0] e;
        for (int i = 0; i < n; i++) begin
            rd_en[p] = 1'b1;
            @(negedge clk);
            rd_en[p] = 1'b0;
            if (act(p) && lvl[p] > 0) begin
                e = word(p, rcnt[p]);
                rcnt[p]++;
                lvl[p]--;
                last[p] = e;
            end else begin
                e = last[p];
            end
            chk(tag, rd_data[p*DW +: DW], e);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (any requirement) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 req after reset", 64'(req), 64'd0);
        chk("R1 ufl after reset", 64'(ufl), 64'd0);
        chk("R1 rd_data after reset", rd_data[DW-1:0] | rd_data[2*DW-1:DW] | rd_data[3*DW-1:2*DW], 64'd0);

        cfg_en = 3'b111;
        @(negedge clk);
        chk("R4 empty enabled planes request", 64'(req), 64'b111);

        // table walk: R2 order, R3 drop, R4 low, R5 hysteresis, R7 underflow
        for (int v = 0; v < 9; v++) begin
            if (VEC[v][18]) take(int'(VEC[v][17:16]), int'(VEC[v][15:6]), "R2 read order");
            else            put(int'(VEC[v][17:16]), int'(VEC[v][15:6]));
            chk($sformatf("R4 R5 req vector %0d", v), 64'(req), 64'(VEC[v][5:3]));
            chk($sformatf("R7 ufl vector %0d", v), 64'(ufl), 64'(VEC[v][2:0]));
        end

        // R7 write-one-to-clear
        ufl_clr = 3'b100;
        @(negedge clk);
        ufl_clr = 3'b000;
        chk("R7 ufl cleared", 64'(ufl), 64'd0);

        // R3 extra words were dropped; R8 underflow holds last word
        take(2, 1, "R3 R8 hold after full drop");
        chk("R3 R8 last word value", rd_data[2*DW +: DW], word(2, 127));
        chk("R7 ufl set again", 64'(ufl), 64'b100);

        // R7 set wins over clear
        rd_en[2] = 1'b1;
        ufl_clr  = 3'b100;
        @(negedge clk);
        rd_en[2] = 1'b0;
        ufl_clr  = 3'b000;
        chk("R7 set wins over clear", 64'(ufl), 64'b100);
        ufl_clr = 3'b100;
        @(negedge clk);
        ufl_clr = 3'b000;
        chk("R7 clear alone", 64'(ufl), 64'd0);

        // R6 disabled plane
        cfg_en = 3'b110;
        @(negedge clk);
        chk("R6 disabled plane no req", 64'(req), 64'b110);
        take(0, 1, "R6 disabled read no effect");
        chk("R6 disabled read no ufl", 64'(ufl), 64'd0);

        // R9 mode change ignored while planes enabled
        cfg_merge = 1'b1;
        cfg_sel   = 2'd1;
        @(negedge clk);
        chk("R9 ignored merge keeps req", 64'(req), 64'b110);
        take(1, 1, "R9 ignored merge keeps data");

        // R10 accepted with all planes disabled, flush
        cfg_en = 3'b000;
        @(negedge clk);
        mm = 1;
        msel = 1;
        for (int p = 0; p < 3; p++) begin
            lvl[p] = 0;
            rcnt[p] = wcnt[p];
        end
        cfg_en = 3'b011;
        @(negedge clk);
        chk("R10 R12 flushed, only selected requests", 64'(req), 64'b010);
        take(1, 1, "R10 flushed store underflows");
        chk("R10 flush leaves store empty", 64'(ufl), 64'b010);
        ufl_clr = 3'b010;
        @(negedge clk);
        ufl_clr = 3'b000;

        // R12 suppressed plane
        put(0, 5);
        take(0, 1, "R12 suppressed read no effect");
        chk("R12 suppressed no ufl", 64'(ufl), 64'd0);

        // R11 merged capacity and thresholds
        put(1, 380);
        chk("R11 merged high threshold 380", 64'(req), 64'd0);
        take(1, 27, "R11 merged data order");
        chk("R11 merged above low threshold", 64'(req), 64'd0);
        take(1, 1, "R11 merged data order");
        chk("R11 merged low threshold 352", 64'(req), 64'b010);
        take(1, 352, "R11 order across banks");
        put(1, 390);
        chk("R3 R11 merged full at 384", 64'(req), 64'd0);
        take(1, 384, "R3 R11 full merged drain");
        chk("R11 no underflow draining exactly capacity", 64'(ufl), 64'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule